// File: doc/BRIEF.md
# Warp Divergence and Reconvergence Stack

This block keeps the control-flow state of one warp of 32 threads that share a single program counter. It holds the current PC and an active mask that marks which threads take part in the instruction at that PC. Every cycle it drives both to the fetch and issue stage. The issue stage reports back in one of two ways: a plain instruction retired (`step_i`), or a branch retired (`br_i`). A branch comes with a per-thread taken vector, a target PC and a reconvergence PC.

When the active threads all go the same way, only the PC moves. When they split, the block runs the two sides one after the other. It first saves a merge entry and a not-taken entry on a stack, then runs the taken side. When the PC would reach the reconvergence point, the block pops the not-taken entry and runs that side. When the not-taken side reaches the same point, the block pops the merge entry and the warp continues with the full mask from before the branch. Nested branches stack in last-in, first-out order. A split that does not fit in the stack sets a sticky error flag.

Top module: `warp_reconv_stack`

## Requirements
- R1: While `rst_n` is low, and after it is released, the PC equals `RESET_PC` (default 0), the mask is all ones, `overflow_o` is 0 and the stack is empty.
- R2: A cycle with neither `step_i` nor `br_i` keeps PC and mask unchanged. `step_i` alone advances the PC by 1 and keeps the mask, unless R5/R6 applies.
- R3: On a branch where all active threads are taken (taken bits of inactive threads are ignored), the PC becomes the target. Where no active thread is taken, the PC becomes PC+1. In both cases the mask is kept and nothing is pushed.
- R4: On a divergent branch with target, fall-through (PC+1) and reconvergence PC all distinct, the block pushes a merge entry and a not-taken entry. The PC becomes the target and the mask becomes `taken & mask`.
- R5: When the next PC produced by a step or uniform branch equals the reconvergence PC of the top entry, the top entry is popped. If it is a not-taken entry, PC becomes the fall-through of the branch and the mask becomes `mask & ~taken` of that branch.
- R6: When the not-taken side reaches the reconvergence PC, the merge entry is popped. PC becomes the reconvergence PC and the mask becomes the mask from before the branch.
- R7: A divergent branch whose target equals the reconvergence PC runs only the not-taken side: PC+1 with the not-taken mask. One whose fall-through equals it runs only the taken side. If both equal it, the branch acts as a jump to it with the mask kept. In each case the warp merges back to the full mask at the reconvergence PC.
- R8: Nested divergent regions are resolved last-in, first-out: the inner region merges before the outer one resumes.
- R9: A divergent branch that needs more entries than the `DEPTH` stack has free sets `overflow_o`, leaves PC and mask unchanged and pushes nothing. `overflow_o` stays set until reset.
- R10: When `step_i` and `br_i` are both high, the branch is taken and the step is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | A non-branch instruction at the current PC retired |
| br_i | input | 1 | A branch at the current PC retired |
| br_taken_i | input | LANES | Per-thread branch direction, 1 = taken |
| br_target_i | input | PCW | Branch target PC |
| br_reconv_i | input | PCW | Reconvergence PC of the branch |
| pc_o | output | PCW | Current warp PC |
| mask_o | output | LANES | Current active thread mask |
| overflow_o | output | 1 | Sticky stack overflow error |

## Verification
Every stack fault stays hidden until the warp reaches a reconvergence PC. A bad saved PC or mask, a wrong entry order, or a count that is off by one shows up at `pc_o`/`mask_o` one cycle after the step or branch that reaches that point. The bench therefore drives every region to its merge point and checks the outputs one cycle after that step or branch. Nested regions and single-sided splits are driven the same way. A bad free-slot calculation shows up in the cycle after the split that crosses the `DEPTH` limit, as a wrong `overflow_o` or a PC that moved.

// File: rtl/wrs_pkg.sv
package wrs_pkg;

    // Outcome of a retired branch as seen by the controller
    typedef enum logic [1:0] {
        BK_NONE   = 2'd0,  // no branch effect
        BK_JUMP   = 2'd1,  // whole warp moves, no stack entry
        BK_SPLIT1 = 2'd2,  // one side empty: merge entry only
        BK_SPLIT2 = 2'd3   // both sides live: merge + not-taken entry
    } br_kind_e;

endpackage

// File: rtl/wrs_branch_eval.sv
module wrs_branch_eval
    import wrs_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PCW   = 32
) (
    input  logic             br_i,
    input  logic [LANES-1:0] act_i,
    input  logic [LANES-1:0] taken_i,
    input  logic [PCW-1:0]   pc_i,
    input  logic [PCW-1:0]   target_i,
    input  logic [PCW-1:0]   reconv_i,
    output br_kind_e         kind_o,
    output logic [PCW-1:0]   go_pc_o,
    output logic [LANES-1:0] go_mask_o,
    output logic [PCW-1:0]   sv_pc_o,
    output logic [LANES-1:0] sv_mask_o
);

    logic [LANES-1:0] tk_mask;
    logic [LANES-1:0] nt_mask;
    logic [PCW-1:0]   fall_pc;

    always_comb begin
        tk_mask   = taken_i & act_i;
        nt_mask   = act_i & ~taken_i;
        fall_pc   = pc_i + PCW'(1);

        kind_o    = BK_NONE;
        go_pc_o   = pc_i;
        go_mask_o = act_i;
        sv_pc_o   = fall_pc;
        sv_mask_o = nt_mask;

        if (br_i && (act_i != '0)) begin
            if (tk_mask == act_i) begin
                kind_o  = BK_JUMP;
                go_pc_o = target_i;
            end else if (tk_mask == '0) begin
                kind_o  = BK_JUMP;
                go_pc_o = fall_pc;
            end else if ((target_i == reconv_i) && (fall_pc == reconv_i)) begin
                kind_o  = BK_JUMP;
                go_pc_o = reconv_i;
            end else if (target_i == reconv_i) begin
                // taken side is empty: run the not-taken side only
                kind_o    = BK_SPLIT1;
                go_pc_o   = fall_pc;
                go_mask_o = nt_mask;
            end else if (fall_pc == reconv_i) begin
                // not-taken side is empty: run the taken side only
                kind_o    = BK_SPLIT1;
                go_pc_o   = target_i;
                go_mask_o = tk_mask;
            end else begin
                kind_o    = BK_SPLIT2;
                go_pc_o   = target_i;
                go_mask_o = tk_mask;
            end
        end
    end

endmodule

// File: rtl/wrs_stack.sv
module wrs_stack #(
    parameter int LANES = 32,
    parameter int PCW   = 32,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       push_n_i,
    input  logic [PCW-1:0]   pa_pc_i,
    input  logic [LANES-1:0] pa_mask_i,
    input  logic [PCW-1:0]   pa_rpc_i,
    input  logic [PCW-1:0]   pb_pc_i,
    input  logic [LANES-1:0] pb_mask_i,
    input  logic [PCW-1:0]   pb_rpc_i,
    input  logic             pop_i,
    output logic [PCW-1:0]   top_pc_o,
    output logic [LANES-1:0] top_mask_o,
    output logic [PCW-1:0]   top_rpc_o,
    output logic [CW-1:0]    cnt_o
);

    typedef struct packed {
        logic [PCW-1:0]   pc;
        logic [LANES-1:0] mask;
        logic [PCW-1:0]   rpc;
    } ent_t;

    typedef struct packed {
        logic [CW-1:0]         cnt;
        ent_t [DEPTH-1:0]      ent;
    } stk_t;

    stk_t st_d, st_q;
    ent_t push_a, push_b, top_e;

    always_comb begin
        push_a = '{pc: pa_pc_i, mask: pa_mask_i, rpc: pa_rpc_i};
        push_b = '{pc: pb_pc_i, mask: pb_mask_i, rpc: pb_rpc_i};
        st_d   = st_q;
        top_e  = '0;

        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.cnt == CW'(i + 1)) top_e = st_q.ent[i];
        end

        if (pop_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end else if (push_n_i != 2'd0) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == st_q.cnt) st_d.ent[i] = push_a;
                if ((push_n_i == 2'd2) && (CW'(i) == st_q.cnt + CW'(1))) st_d.ent[i] = push_b;
            end
            st_d.cnt = st_q.cnt + CW'(push_n_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign top_pc_o   = top_e.pc;
    assign top_mask_o = top_e.mask;
    assign top_rpc_o  = top_e.rpc;
    assign cnt_o      = st_q.cnt;

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (st_q.cnt != '0)); // R5
    AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n_i != 2'd0) |-> ((int'(st_q.cnt) + int'(push_n_i)) <= DEPTH)); // R9
    AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (push_n_i == 2'd0)); // R8

endmodule

// File: rtl/warp_reconv_stack.sv
module warp_reconv_stack
    import wrs_pkg::*;
#(
    parameter int             LANES    = 32,
    parameter int             PCW      = 32,
    parameter int             DEPTH    = 8,
    parameter logic [PCW-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             br_i,
    input  logic [LANES-1:0] br_taken_i,
    input  logic [PCW-1:0]   br_target_i,
    input  logic [PCW-1:0]   br_reconv_i,
    output logic [PCW-1:0]   pc_o,
    output logic [LANES-1:0] mask_o,
    output logic             overflow_o
);

    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PCW-1:0]   pc;
        logic [LANES-1:0] mask;
        logic             ovf;
    } ctl_t;

    ctl_t st_d, st_q;

    br_kind_e         kind;
    logic [PCW-1:0]   go_pc, sv_pc;
    logic [LANES-1:0] go_mask, sv_mask;
    logic [1:0]       push_n;
    logic             pop;
    logic [PCW-1:0]   top_pc, top_rpc;
    logic [LANES-1:0] top_mask;
    logic [CW-1:0]    cnt;

    logic             cand_v;
    logic [PCW-1:0]   cand_pc;
    logic [LANES-1:0] cand_mask;
    int               need;

    wrs_branch_eval #(.LANES(LANES), .PCW(PCW)) u_eval (
        .br_i      (br_i),
        .act_i     (st_q.mask),
        .taken_i   (br_taken_i),
        .pc_i      (st_q.pc),
        .target_i  (br_target_i),
        .reconv_i  (br_reconv_i),
        .kind_o    (kind),
        .go_pc_o   (go_pc),
        .go_mask_o (go_mask),
        .sv_pc_o   (sv_pc),
        .sv_mask_o (sv_mask)
    );

    // merge entry goes in first (port a), not-taken entry on top (port b)
    wrs_stack #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_n_i   (push_n),
        .pa_pc_i    (br_reconv_i),
        .pa_mask_i  (st_q.mask),
        .pa_rpc_i   (br_reconv_i),
        .pb_pc_i    (sv_pc),
        .pb_mask_i  (sv_mask),
        .pb_rpc_i   (br_reconv_i),
        .pop_i      (pop),
        .top_pc_o   (top_pc),
        .top_mask_o (top_mask),
        .top_rpc_o  (top_rpc),
        .cnt_o      (cnt)
    );

    always_comb begin
        st_d      = st_q;
        push_n    = 2'd0;
        pop       = 1'b0;
        cand_v    = 1'b0;
        cand_pc   = st_q.pc;
        cand_mask = st_q.mask;
        need      = (kind == BK_SPLIT2) ? 2 : ((kind == BK_SPLIT1) ? 1 : 0);

        if (need != 0) begin
            if ((int'(cnt) + need) > DEPTH) begin
                st_d.ovf = 1'b1;
            end else begin
                push_n    = 2'(need);
                st_d.pc   = go_pc;
                st_d.mask = go_mask;
            end
        end else if (kind == BK_JUMP) begin
            cand_v    = 1'b1;
            cand_pc   = go_pc;
            cand_mask = go_mask;
        end else if (step_i && !br_i) begin
            cand_v    = 1'b1;
            cand_pc   = st_q.pc + PCW'(1);
        end

        if (cand_v) begin
            if ((cnt != '0) && (cand_pc == top_rpc)) begin
                pop       = 1'b1;
                st_d.pc   = top_pc;
                st_d.mask = top_mask;
            end else begin
                st_d.pc   = cand_pc;
                st_d.mask = cand_mask;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{pc: RESET_PC, mask: '1, ovf: 1'b0};
        else        st_q <= st_d;
    end

    assign pc_o       = st_q.pc;
    assign mask_o     = st_q.mask;
    assign overflow_o = st_q.ovf;

    AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mask != '0); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !br_i) |=> ($stable(st_q.pc) && $stable(st_q.mask))); // R2
    AST_SPLIT_NARROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n != 2'd0) |=> (((st_q.mask & ~$past(st_q.mask)) == '0) && (st_q.mask != $past(st_q.mask)))); // R4
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf); // R9
    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovf) |-> ($stable(st_q.pc) && $stable(st_q.mask))); // R9

endmodule

// File: tb/sim_warp_reconv_stack.sv
`timescale 1ns/1ps
module sim_warp_reconv_stack;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic        br_i = 1'b0;
    logic [31:0] br_taken_i = '0;
    logic [31:0] br_target_i = '0;
    logic [31:0] br_reconv_i = '0;
    logic [31:0] pc_o;
    logic [31:0] mask_o;
    logic        overflow_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    warp_reconv_stack u0 (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .br_i(br_i),
        .br_taken_i(br_taken_i), .br_target_i(br_target_i), .br_reconv_i(br_reconv_i),
        .pc_o(pc_o), .mask_o(mask_o), .overflow_o(overflow_o)
    );

    typedef struct packed {
        logic        st;
        logic        br;
        logic [31:0] tk;
        logic [31:0] tg;
        logic [31:0] rc;
        logic [31:0] pc;
        logic [31:0] mk;
        logic        ov;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 32'h0,        32'd0,   32'd0,   32'd1,   32'hFFFFFFFF, 1'b0, 8'd2},  // R2 step
        '{1'b0, 1'b1, 32'hFFFFFFFF, 32'd10,  32'd20,  32'd10,  32'hFFFFFFFF, 1'b0, 8'd3},  // R3 all taken
        '{1'b0, 1'b1, 32'h0,        32'd50,  32'd60,  32'd11,  32'hFFFFFFFF, 1'b0, 8'd3},  // R3 none taken
        '{1'b0, 1'b1, 32'h0000FFFF, 32'd30,  32'd40,  32'd30,  32'h0000FFFF, 1'b0, 8'd4},  // R4 split
        '{1'b1, 1'b0, 32'h0,        32'd0,   32'd0,   32'd31,  32'h0000FFFF, 1'b0, 8'd2},  // R2
        '{1'b0, 1'b1, 32'hFFFFFFFF, 32'd39,  32'd99,  32'd39,  32'h0000FFFF, 1'b0, 8'd3},  // R3 inactive bits ignored
        '{1'b1, 1'b0, 32'h0,        32'd0,   32'd0,   32'd12,  32'hFFFF0000, 1'b0, 8'd5},  // R5 to not-taken side
        '{1'b0, 1'b1, 32'h00FF0000, 32'd70,  32'd80,  32'd70,  32'h00FF0000, 1'b0, 8'd8},  // R8 nested split
        '{1'b1, 1'b0, 32'h0,        32'd0,   32'd0,   32'd71,  32'h00FF0000, 1'b0, 8'd2},  // R2
        '{1'b0, 1'b1, 32'h00FF0000, 32'd80,  32'd90,  32'd13,  32'hFF000000, 1'b0, 8'd5},  // R5 jump reaches merge
        '{1'b0, 1'b1, 32'hFF000000, 32'd80,  32'd0,   32'd80,  32'hFFFF0000, 1'b0, 8'd6},  // R6 inner merge
        '{1'b1, 1'b0, 32'h0,        32'd0,   32'd0,   32'd81,  32'hFFFF0000, 1'b0, 8'd2},  // R2
        '{1'b0, 1'b1, 32'hFFFFFFFF, 32'd40,  32'd0,   32'd40,  32'hFFFFFFFF, 1'b0, 8'd6},  // R6 outer merge (R8)
        '{1'b1, 1'b1, 32'hFFFFFFFF, 32'd200, 32'd0,   32'd200, 32'hFFFFFFFF, 1'b0, 8'd10}, // R10 branch wins
        '{1'b0, 1'b1, 32'h0000000F, 32'd210, 32'd210, 32'd201, 32'hFFFFFFF0, 1'b0, 8'd7},  // R7 taken side empty
        '{1'b0, 1'b1, 32'hFFFFFFFF, 32'd209, 32'd0,   32'd209, 32'hFFFFFFF0, 1'b0, 8'd3},  // R3
        '{1'b1, 1'b0, 32'h0,        32'd0,   32'd0,   32'd210, 32'hFFFFFFFF, 1'b0, 8'd7},  // R7 merge
        '{1'b0, 1'b1, 32'hF0000000, 32'd300, 32'd211, 32'd300, 32'hF0000000, 1'b0, 8'd7},  // R7 not-taken empty
        '{1'b0, 1'b1, 32'hFFFFFFFF, 32'd211, 32'd0,   32'd211, 32'hFFFFFFFF, 1'b0, 8'd7},  // R7 merge
        '{1'b0, 1'b1, 32'h00FF00FF, 32'd212, 32'd212, 32'd212, 32'hFFFFFFFF, 1'b0, 8'd7},  // R7 both sides empty
        '{1'b1, 1'b0, 32'h0,        32'd0,   32'd0,   32'd213, 32'hFFFFFFFF, 1'b0, 8'd7},  // R7 nothing pushed
        '{1'b0, 1'b0, 32'h0,        32'd0,   32'd0,   32'd213, 32'hFFFFFFFF, 1'b0, 8'd2}   // R2 idle hold
    };

    task automatic chk(input int req, input logic [31:0] epc, input logic [31:0] emk, input logic eov);
        n_checks++;
        if (pc_o !== epc || mask_o !== emk || overflow_o !== eov) begin
            n_fail++;
            $display("FAIL R%0d: pc=%0d mask=%h ovf=%b, expected pc=%0d mask=%h ovf=%b",
                     req, pc_o, mask_o, overflow_o, epc, emk, eov);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic op(input logic s, input logic b, input logic [31:0] tk,
                      input logic [31:0] tg, input logic [31:0] rc);
        step_i = s; br_i = b; br_taken_i = tk; br_target_i = tg; br_reconv_i = rc;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(1, 32'd0, 32'hFFFFFFFF, 1'b0);                     // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        chk(1, 32'd0, 32'hFFFFFFFF, 1'b0);                     // R1 after release

        for (int i = 0; i < NV; i++) begin
            op(VEC[i].st, VEC[i].br, VEC[i].tk, VEC[i].tg, VEC[i].rc);
            chk(int'(VEC[i].rq), VEC[i].pc, VEC[i].mk, VEC[i].ov);
        end

        // R9: fill an 8-deep stack with four splits, the fifth overflows
        op(1'b0, 1'b1, 32'h0000FFFF, 32'd1000, 32'd5000);
        chk(4, 32'd1000, 32'h0000FFFF, 1'b0);
        op(1'b0, 1'b1, 32'h000000FF, 32'd1100, 32'd5001);
        chk(4, 32'd1100, 32'h000000FF, 1'b0);
        op(1'b0, 1'b1, 32'h0000000F, 32'd1200, 32'd5002);
        chk(4, 32'd1200, 32'h0000000F, 1'b0);
        op(1'b0, 1'b1, 32'h00000003, 32'd1300, 32'd5003);
        chk(9, 32'd1300, 32'h00000003, 1'b0);
        op(1'b0, 1'b1, 32'h00000001, 32'd1400, 32'd5004);
        chk(9, 32'd1300, 32'h00000003, 1'b1);                  // R9 flag set, state held
        op(1'b1, 1'b0, 32'h0, 32'd0, 32'd0);
        chk(9, 32'd1301, 32'h00000003, 1'b1);                  // R9 sticky
        op(1'b0, 1'b0, 32'h0, 32'd0, 32'd0);
        chk(9, 32'd1301, 32'h00000003, 1'b1);                  // R9 sticky while idle

        // R1: reset clears flag, PC, mask and stack
        rst_n = 1'b0;
        @(negedge clk);
        chk(1, 32'd0, 32'hFFFFFFFF, 1'b0);
        rst_n = 1'b1;
        op(1'b1, 1'b0, 32'h0, 32'd0, 32'd0);
        chk(1, 32'd1, 32'hFFFFFFFF, 1'b0);                     // R1 no stale entry pops
        op(1'b0, 1'b1, 32'h0, 32'd5001, 32'd0);
        chk(1, 32'd2, 32'hFFFFFFFF, 1'b0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

endmodule